// File: doc/BRIEF.md
# Audio Time-Shift Playback Controller

This block sits between an audio converter path and an external sample memory and turns that memory into a circular history of the incoming audio. Every sample strobe captures one 12-bit sample and writes it into the next location of the ring. It then reads one sample back from a separate play position and drives it to the output. By moving the play position, a listener can pause the audio, skip back, hear it reversed, or return to the live signal. Recording never stops in any of these modes.

Three debounced button levels control the block. A tap on the rewind button skips the play position back by a fixed number of samples. Holding it past a threshold, counted in sample strobes, switches to continuous reverse until the button is let go. The pause button toggles between pause and play. The live button snaps playback back to the newest sample. All pointer moves are clamped, so playback never leaves the span of samples still held in the ring.

Buffer depth (as an address width), skip length, hold threshold, reverse step and live lag are parameters. The defaults give more than ten minutes of history at 50 kS/s, a 15-second skip and a 3-second hold. A bench can shrink all of them.

Top module: `tshift_ctrl`

## Requirements
- R1: Each sample strobe causes exactly one memory write, at the address after the previous write (wrapping at the ring depth). The 16-bit write word carries the captured sample in bits 11:0 and zeros in bits 15:12.
- R2: On each strobe the write is issued first and the read (if any) second. A request keeps its address and direction stable until the memory acknowledges it.
- R3: After reset, and after a live-button press, the block is in live mode with the live LED lit. With LIVE_LAG = 0, each strobe outputs the sample written on that same strobe.
- R4: A rewind press released before HOLD_TICKS strobes have been counted while it was held moves the play position back by SKIP_LEN samples. Playback then continues in play mode, or stays in pause mode if the block was paused.
- R5: When rewind has been held for HOLD_TICKS strobes, reverse mode starts on that strobe. Each strobe then outputs the sample at the play position and steps the position back by REV_STEP. Releasing the button resumes forward play from where reverse stopped.
- R6: No skip or reverse step moves the play position past the oldest sample still held. If paused playback is overtaken by recording, the play position is pulled forward to the oldest sample still held.
- R7: A read is only issued to an address that has already been written and not yet overwritten: its distance behind the write pointer is at least 1 and no more than the fill level.
- R8: In pause mode no reads occur, no output strobe is given, and the output sample is zero. Writing continues. Pressing pause again resumes from exactly the paused sample.
- R9: The pause LED is lit only in pause mode, the live LED only in live mode, and the power LED always.
- R10: In play mode the output advances by one sample per strobe, so the delay behind the input stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle sample strobe |
| smp_in | input | 12 | Input audio sample |
| btn_rew | input | 1 | Rewind button level |
| btn_pause | input | 1 | Pause/play button level |
| btn_live | input | 1 | Jump-to-live button level |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 16 | Write word |
| mem_rdata | input | 16 | Read word, valid with mem_ack |
| mem_ack | input | 1 | Access done |
| audio_out | output | 12 | Played sample |
| audio_vld | output | 1 | Pulses when audio_out is updated by a read |
| led_pause | output | 1 | Pause mode indicator |
| led_live | output | 1 | Live mode indicator |
| led_power | output | 1 | Power indicator, always on |

## Verification
The hardest situation to reach is clamping at the oldest edge of the ring. It needs a full ring and then either a pause long enough for recording to lap the play position, or enough skips and reverse steps to reach the oldest sample. The bench scales the ring to 64 words, fills it past wrap-around in live mode, then stacks short rewinds and a long reverse hold until the position sits on the oldest sample. It then pauses for more strobes than the ring holds before resuming. A reference model in sample-index terms predicts every played sample.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  typedef enum logic [1:0] {
    MD_LIVE  = 2'd0,
    MD_PLAY  = 2'd1,
    MD_PAUSE = 2'd2,
    MD_REV   = 2'd3
  } tsc_mode_e;

  function automatic logic [31:0] tsc_min(input logic [31:0] a, input logic [31:0] b);
    return (a < b) ? a : b;
  endfunction

  // Position that lies want samples behind wr, never deeper than fill.
  function automatic logic [31:0] tsc_back(input logic [31:0] wr,
                                           input logic [31:0] want,
                                           input logic [31:0] fill);
    return wr - tsc_min(want, fill);
  endfunction

endpackage

// File: rtl/tsc_hold.sv
module tsc_hold #(
  parameter int HOLD_TICKS = 150000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic btn,
  output logic short_rel,
  output logic rev_start,
  output logic rev_end
);
  localparam int CW = $clog2(HOLD_TICKS + 1);

  logic [CW-1:0] cnt;
  logic          btn_q;
  logic          is_long;
  logic          release_ev;

  assign is_long    = (cnt == CW'(HOLD_TICKS));
  assign release_ev = btn_q && !btn;
  assign short_rel  = release_ev && !is_long;
  assign rev_end    = release_ev && is_long;
  assign rev_start  = btn && strobe && (cnt == CW'(HOLD_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      btn_q <= 1'b0;
    end else begin
      btn_q <= btn;
      if (!btn)
        cnt <= '0;
      else if (strobe && !is_long)
        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tsc_mem_seq.sv
module tsc_mem_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic do_read,
  input  logic ack,
  output logic req,
  output logic we,
  output logic idle,
  output logic wr_done,
  output logic rd_done
);
  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD} seq_e;
  seq_e st;

  assign idle    = (st == S_IDLE);
  assign req     = (st != S_IDLE);
  assign we      = (st == S_WR);
  assign wr_done = (st == S_WR) && ack;
  assign rd_done = (st == S_RD) && ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (strobe) st <= S_WR;
        S_WR:   if (ack) st <= do_read ? S_RD : S_IDLE;
        S_RD:   if (ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tshift_ctrl.sv
module tshift_ctrl
  import tsc_pkg::*;
#(
  parameter int ADDR_W     = 25,
  parameter int SKIP_LEN   = 750000,
  parameter int HOLD_TICKS = 150000,
  parameter int REV_STEP   = 4,
  parameter int LIVE_LAG   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [11:0]       smp_in,
  input  logic              btn_rew,
  input  logic              btn_pause,
  input  logic              btn_live,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              mem_ack,
  output logic [11:0]       audio_out,
  output logic              audio_vld,
  output logic              led_pause,
  output logic              led_live,
  output logic              led_power
);
  localparam logic [ADDR_W-1:0] FILL_MAX = {ADDR_W{1'b1}};

  tsc_mode_e         mode;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr, fill;
  logic [11:0]       sample_q;
  logic              pause_q, live_q;
  logic              pend_pause, pend_live, pend_skip;

  logic seq_idle, wr_done, rd_done;
  logic short_rel, rev_start, rev_end;
  logic apply_ok;

  logic [ADDR_W-1:0] wr_next, fill_next, lag_after_wr, clamp_rd, lag_now;
  logic [ADDR_W-1:0] rd_rev, rd_skip, rd_live;
  logic              unused_hi;

  tsc_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst_n(rst_n), .strobe(smp_stb), .btn(btn_rew),
    .short_rel(short_rel), .rev_start(rev_start), .rev_end(rev_end)
  );

  tsc_mem_seq u_seq (
    .clk(clk), .rst_n(rst_n), .strobe(smp_stb),
    .do_read(mode != MD_PAUSE), .ack(mem_ack),
    .req(mem_req), .we(mem_we), .idle(seq_idle),
    .wr_done(wr_done), .rd_done(rd_done)
  );

  // Pointer arithmetic
  assign wr_next      = wr_ptr + 1'b1;
  assign fill_next    = (fill == FILL_MAX) ? fill : fill + 1'b1;
  assign lag_after_wr = wr_next - rd_ptr;
  assign clamp_rd     = wr_next - fill_next;
  assign lag_now      = wr_ptr - rd_ptr;
  assign rd_rev  = ADDR_W'(tsc_back(32'(wr_ptr), 32'(lag_now) + 32'(REV_STEP), 32'(fill)));
  assign rd_skip = ADDR_W'(tsc_back(32'(wr_ptr), 32'(lag_now) + 32'(SKIP_LEN), 32'(fill)));
  assign rd_live = ADDR_W'(tsc_back(32'(wr_ptr), 32'(LIVE_LAG), 32'(fill)));

  assign apply_ok  = seq_idle && !smp_stb;
  assign mem_addr  = mem_we ? wr_ptr : rd_ptr;
  assign mem_wdata = {4'h0, sample_q};
  assign audio_vld = rd_done;
  assign led_pause = (mode == MD_PAUSE);
  assign led_live  = (mode == MD_LIVE);
  assign led_power = 1'b1;
  assign unused_hi = ^mem_rdata[15:12];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= MD_LIVE;
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      fill       <= '0;
      sample_q   <= '0;
      audio_out  <= '0;
      pause_q    <= 1'b0;
      live_q     <= 1'b0;
      pend_pause <= 1'b0;
      pend_live  <= 1'b0;
      pend_skip  <= 1'b0;
    end else begin
      pause_q <= btn_pause;
      live_q  <= btn_live;
      if (smp_stb && seq_idle) sample_q <= smp_in;

      if (wr_done) begin
        wr_ptr <= wr_next;
        fill   <= fill_next;
        if (lag_after_wr == '0 || lag_after_wr > fill_next) rd_ptr <= clamp_rd;
      end

      if (rd_done) begin
        audio_out <= mem_rdata[11:0];
        rd_ptr    <= (mode == MD_REV) ? rd_rev : rd_ptr + 1'b1;
      end

      if (apply_ok) begin
        if (pend_live) begin
          rd_ptr    <= rd_live;
          mode      <= MD_LIVE;
          pend_live <= 1'b0;
        end else if (pend_skip) begin
          rd_ptr    <= rd_skip;
          if (mode != MD_PAUSE) mode <= MD_PLAY;
          pend_skip <= 1'b0;
        end else if (pend_pause) begin
          mode       <= (mode == MD_PAUSE) ? MD_PLAY : MD_PAUSE;
          pend_pause <= 1'b0;
        end
      end

      if (rev_start) mode <= MD_REV;
      if (rev_end)   mode <= MD_PLAY;
      if (mode == MD_PAUSE) audio_out <= '0;

      if (btn_pause && !pause_q) pend_pause <= 1'b1;
      if (btn_live && !live_q)   pend_live  <= 1'b1;
      if (short_rel)             pend_skip  <= 1'b1;
    end
  end
endmodule

// File: rtl/tshift_ctrl_chk.sv
module tshift_ctrl_chk #(
  parameter int ADDR_W = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic [ADDR_W-1:0] fill,
  input logic              audio_vld,
  input logic              led_pause
);
  logic              rd_req;
  logic [ADDR_W-1:0] rd_dist;

  assign rd_req  = mem_req && !mem_we;
  assign rd_dist = wr_ptr - mem_addr;

  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R2
  rd_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> $past(mem_ack && mem_we));

  // R7
  rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_dist != '0) && (rd_dist <= fill));

  // R1
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack |=> wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1));

  // R8
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    led_pause |-> !audio_vld && !rd_req);
endmodule

bind tshift_ctrl tshift_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .wr_ptr(wr_ptr), .fill(fill),
  .audio_vld(audio_vld), .led_pause(led_pause)
);

// File: tb/tshift_ctrl_test.sv
`timescale 1ns/1ps
module tshift_ctrl_test;
  localparam int AW   = 6;
  localparam int DEP  = 1 << AW;
  localparam int SKIP = 10;
  localparam int HOLD = 5;
  localparam int STEP = 2;
  localparam int LAG  = 0;

  logic clk = 0, rst_n = 0;
  logic smp_stb = 0, btn_rew = 0, btn_pause = 0, btn_live = 0;
  logic [11:0] smp_in = '0;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [11:0] audio_out;
  logic audio_vld, led_pause, led_live, led_power;

  always #4 clk = ~clk;

  tshift_ctrl #(.ADDR_W(AW), .SKIP_LEN(SKIP), .HOLD_TICKS(HOLD),
                .REV_STEP(STEP), .LIVE_LAG(LAG)) uut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_in(smp_in),
    .btn_rew(btn_rew), .btn_pause(btn_pause), .btn_live(btn_live),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .audio_out(audio_out), .audio_vld(audio_vld),
    .led_pause(led_pause), .led_live(led_live), .led_power(led_power));

  // Memory model with wait states
  logic [15:0] mem [DEP];
  int wt, wr_cnt, vld_cnt, last_waddr, last_wdata;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 0; wt <= 0; mem_rdata <= '0; wr_cnt <= 0; vld_cnt <= 0;
    end else begin
      if (audio_vld) vld_cnt <= vld_cnt + 1;
      if (mem_ack) mem_ack <= 0;
      else if (mem_req) begin
        if (wt == 2) begin
          wt <= 0; mem_ack <= 1;
          if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            last_waddr <= int'(mem_addr); last_wdata <= int'(mem_wdata);
            wr_cnt <= wr_cnt + 1;
          end else mem_rdata <= mem[mem_addr];
        end else wt <= wt + 1;
      end
    end
  end

  int checks = 0, fails = 0;
  int n_wr = 0, p_rd = 0, mode_m = 0, hold_cnt = 0;
  bit rew_held = 0, done = 0;

  function automatic int val(int i); return (i * 37 + 5) % 4096; endfunction
  function automatic int fillm(); return (n_wr < DEP - 1) ? n_wr : DEP - 1; endfunction
  function automatic int oldest(); return n_wr - fillm(); endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_leds(string req);
    check(led_pause == (mode_m == 2), req, int'(led_pause), int'(mode_m == 2));
    check(led_live == (mode_m == 0), req, int'(led_live), int'(mode_m == 0));
    check(led_power == 1'b1, "R9", int'(led_power), 1);
  endtask

  task automatic do_strobe(string req);
    int vb, wb;
    vb = vld_cnt; wb = wr_cnt;
    if (rew_held) begin
      hold_cnt++;
      if (hold_cnt == HOLD) mode_m = 3;
    end
    @(negedge clk); smp_stb = 1; smp_in = 12'(val(n_wr));
    @(negedge clk); smp_stb = 0;
    repeat (14) @(negedge clk);
    check(wr_cnt == wb + 1 && last_waddr == n_wr % DEP, "R1", last_waddr, n_wr % DEP);
    check(last_wdata == val(n_wr), "R1", last_wdata, val(n_wr));
    n_wr++;
    if (p_rd < oldest()) p_rd = oldest();
    if (mode_m != 2) begin
      check(vld_cnt == vb + 1 && int'(audio_out) == val(p_rd), req, int'(audio_out), val(p_rd));
      if (mode_m == 3) p_rd = (p_rd - STEP < oldest()) ? oldest() : p_rd - STEP;
      else p_rd++;
    end else begin
      check(vld_cnt == vb && audio_out == 12'd0, "R8", int'(audio_out), 0);
    end
  endtask

  task automatic rew_press();
    @(negedge clk); btn_rew = 1; rew_held = 1; hold_cnt = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rew_release();
    @(negedge clk); btn_rew = 0; rew_held = 0;
    if (hold_cnt >= HOLD) mode_m = 1;
    else begin
      p_rd = (p_rd - SKIP < oldest()) ? oldest() : p_rd - SKIP;
      if (mode_m != 2) mode_m = 1;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic pause_tap();
    @(negedge clk); btn_pause = 1; repeat (3) @(negedge clk);
    btn_pause = 0; repeat (4) @(negedge clk);
    mode_m = (mode_m == 2) ? 1 : 2;
  endtask

  task automatic live_tap();
    @(negedge clk); btn_live = 1; repeat (3) @(negedge clk);
    btn_live = 0; repeat (4) @(negedge clk);
    p_rd = n_wr - ((LAG < fillm()) ? LAG : fillm());
    mode_m = 0;
  endtask

  task automatic t_reset();
    check(audio_out == 0 && !mem_req, "R3", int'(audio_out), 0);
    check_leds("R9");
  endtask

  task automatic t_live();
    for (int i = 0; i < 8; i++) do_strobe("R3");
    check_leds("R3");
    for (int i = 0; i < 70; i++) do_strobe("R3");
  endtask

  task automatic t_skip();
    rew_press(); do_strobe("R10"); rew_release();
    check_leds("R4");
    do_strobe("R4");
    for (int i = 0; i < 5; i++) do_strobe("R10");
  endtask

  task automatic t_pause();
    pause_tap(); check_leds("R8");
    for (int i = 0; i < 5; i++) do_strobe("R8");
    rew_press(); do_strobe("R8"); rew_release();
    check_leds("R4");
    pause_tap(); check_leds("R9");
    for (int i = 0; i < 3; i++) do_strobe("R8");
  endtask

  task automatic t_reverse();
    rew_press();
    for (int i = 0; i < HOLD + 4; i++) do_strobe("R5");
    check_leds("R5");
    rew_release();
    for (int i = 0; i < 3; i++) do_strobe("R5");
  endtask

  task automatic t_clamp();
    for (int k = 0; k < 8; k++) begin
      rew_press(); do_strobe("R6"); rew_release();
    end
    do_strobe("R6");
    rew_press();
    for (int i = 0; i < HOLD + 30; i++) do_strobe("R6");
    rew_release();
    do_strobe("R6");
  endtask

  task automatic t_pause_wrap();
    pause_tap();
    for (int i = 0; i < 70; i++) do_strobe("R8");
    pause_tap();
    do_strobe("R6");
    do_strobe("R10");
  endtask

  task automatic t_jump_live();
    live_tap(); check_leds("R9");
    for (int i = 0; i < 4; i++) do_strobe("R3");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_live();
    t_skip();
    t_pause();
    t_reverse();
    t_clamp();
    t_pause_wrap();
    t_jump_live();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule